// File: doc/BRIEF.md
# Back-EMF Rotor Position Sampler

This block finds the rotor sector of a three-phase motor from its floating phase voltages. It uses one comparator, reached through an analog input multiplexer that the block steers. A measurement makes two or three ordered comparisons between phase pairs. The outcome of each comparison picks the next pair, and the last outcome yields a sector code from 1 to 6.

Each mux change is followed by a fixed settling wait before the comparator is read through a synchronizer. Comparator noise near a crossing would otherwise give false codes. To guard against this, a measurement is repeated until two back-to-back measurements give the same code. That code is then reported with a single-cycle valid strobe.

A controller raises the request for one cycle and waits for the strobe. Requests that arrive while a measurement sequence is running are dropped.

Top module: `bemf_sense`

## Requirements
- R1: While reset is low and after it is released, `pos_valid_o` is 0, `pos_o` is 0 and the mux is parked at pair code 2 with polarity 0. No strobe appears while no request is made.
- R2: The pair codes are 0 = A/B, 1 = B/C and 2 = C/A. Polarity 0 makes the first-named phase the positive comparator input, and polarity 1 makes the second-named phase positive. Every measurement starts with pair 1, polarity 0 (B positive against C). Step two is pair 0, polarity 1 (B against A). Step three is pair 2, polarity 1 (A against C).
- R3: When B is not above C: if B is above A, the code is 5. Otherwise the code is 1 if A is above C, and 6 if it is not.
- R4: When B is above C: if B is not above A, the code is 2. Otherwise the code is 3 if A is above C, and 4 if it is not.
- R5: "Above" is strict. Equal voltages read as not above, so three equal phases decode to 6.
- R6: The comparator input passes a two-flop synchronizer. Each mux setting is held for SETTLE clock cycles (default 3) before its result is taken. The strobe therefore rises 3·S+1 cycles after the cycle in which the request is raised, where S is the total number of comparison steps in all measurements.
- R7: A code is reported only when two consecutive complete measurements agree. On a mismatch, the newest code becomes the reference and a fresh measurement starts at once.
- R8: `pos_valid_o` is high for exactly one cycle and carries the accepted code. `pos_o` keeps that code until the next accepted result.
- R9: A request raised while a measurement sequence is running has no effect. It neither changes the result or its timing, nor starts another sequence afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Start a position measurement sequence |
| cmp_i | input | 1 | Asynchronous comparator output, 1 when the positive input is higher |
| mux_pair_o | output | 2 | Phase pair routed to the comparator |
| mux_pol_o | output | 1 | Which phase of the pair drives the positive input |
| pos_o | output | 3 | Last accepted rotor sector code (1 to 6) |
| pos_valid_o | output | 1 | One-cycle strobe for a newly accepted code |

## Verification
The assertions assume that the comparator input only changes as a response to the mux setting. They also assume that any change caused by a new setting reaches the synchronizer well inside the settling window, so each decision reflects the pair currently selected. The bench models the three phases as fixed voltages for each measurement and computes the comparator output from the mux outputs. It updates that output on the falling edge after a mux change. It switches to the next voltage set only when it sees pair 1 newly selected, so a voltage change always lands at a measurement boundary and never inside the settling window.

// File: rtl/bemf_pkg.sv
// Shared types for the back-EMF position sampler.
// Assumes three phases named A, B, C and a single shared comparator.
package bemf_pkg;
    // Phase pair routed to the comparator (values are visible on mux_pair_o)
    typedef enum logic [1:0] {
        PAIR_AB = 2'd0,
        PAIR_BC = 2'd1,
        PAIR_CA = 2'd2
    } pair_e;

    // Comparison step inside one measurement
    typedef enum logic [1:0] {
        STEP_BC = 2'd0,
        STEP_BA = 2'd1,
        STEP_AC = 2'd2
    } step_e;

    typedef logic [2:0] pos_code_t;
endpackage

// File: rtl/bemf_sync.sv
// Multi-flop synchronizer for the asynchronous comparator output.
// Assumes STAGES >= 2; output lags the input by STAGES clock edges.
module bemf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Shift one flop per stage, first stage takes the raw input
            always_ff @(posedge clk) begin
                if (!rst_n)      chain_q[g] <= 1'b0;
                else if (g == 0) chain_q[g] <= d_i;
                else             chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/bemf_tree.sv
// Decision-tree sequencer: runs one measurement of two or three comparisons.
// Each mux setting is held SETTLE cycles; the synchronized comparator is
// read on the last of them. done_o/code_o are combinational in that cycle so
// a repeat can begin on the same edge when again_i is high.
// Assumes SETTLE exceeds the synchronizer depth.
module bemf_tree
    import bemf_pkg::*;
#(
    parameter int SETTLE = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  logic      again_i,
    input  logic      cmp_s_i,
    output pair_e     pair_o,
    output logic      pol_o,
    output logic      active_o,
    output logic      done_o,
    output pos_code_t code_o
);
    localparam int CNT_W = $clog2(SETTLE + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE - 1);

    step_e            step_q;
    logic             b_over_c_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last_w;

    assign last_w = active_o && (cnt_q == CNT_LAST);

    // Decode the finishing step into a sector code
    always_comb begin
        done_o = 1'b0;
        code_o = 3'd0;
        if (last_w) begin
            case (step_q)
                STEP_BA: begin
                    if (b_over_c_q && !cmp_s_i) begin
                        done_o = 1'b1;
                        code_o = 3'd2;
                    end else if (!b_over_c_q && cmp_s_i) begin
                        done_o = 1'b1;
                        code_o = 3'd5;
                    end
                end
                STEP_AC: begin
                    done_o = 1'b1;
                    if (b_over_c_q) code_o = cmp_s_i ? 3'd3 : 3'd4;
                    else            code_o = cmp_s_i ? 3'd1 : 3'd6;
                end
                default: ;
            endcase
        end
    end

    // Step through the mux schedule and hold each setting for SETTLE cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o   <= 1'b0;
            step_q     <= STEP_BC;
            b_over_c_q <= 1'b0;
            cnt_q      <= '0;
            pair_o     <= PAIR_CA;
            pol_o      <= 1'b0;
        end else if (!active_o) begin
            if (start_i) begin
                active_o <= 1'b1;
                step_q   <= STEP_BC;
                cnt_q    <= '0;
                pair_o   <= PAIR_BC;
                pol_o    <= 1'b0;
            end
        end else if (!last_w) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (done_o) begin
            if (again_i) begin
                step_q <= STEP_BC;
                cnt_q  <= '0;
                pair_o <= PAIR_BC;
                pol_o  <= 1'b0;
            end else begin
                active_o <= 1'b0;
            end
        end else if (step_q == STEP_BC) begin
            b_over_c_q <= cmp_s_i;
            step_q     <= STEP_BA;
            cnt_q      <= '0;
            pair_o     <= PAIR_AB;
            pol_o      <= 1'b1;
        end else begin
            step_q <= STEP_AC;
            cnt_q  <= '0;
            pair_o <= PAIR_CA;
            pol_o  <= 1'b1;
        end
    end
endmodule

// File: rtl/bemf_agree.sv
// Agreement filter: accepts a code when two consecutive measurements match.
// On a mismatch the newest code becomes the reference and again_o asks the
// sequencer to measure once more. clear_i drops the reference at a new start.
module bemf_agree
    import bemf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clear_i,
    input  logic      done_i,
    input  pos_code_t code_i,
    output logic      again_o,
    output pos_code_t pos_o,
    output logic      valid_o
);
    logic      have_ref_q;
    pos_code_t ref_q;
    logic      match_w;

    assign match_w = have_ref_q && (ref_q == code_i);
    assign again_o = done_i && !match_w;

    // Track the reference code and publish matched results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_ref_q <= 1'b0;
            ref_q      <= 3'd0;
            pos_o      <= 3'd0;
            valid_o    <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (clear_i) begin
                have_ref_q <= 1'b0;
            end else if (done_i) begin
                if (match_w) begin
                    valid_o    <= 1'b1;
                    pos_o      <= code_i;
                    have_ref_q <= 1'b0;
                end else begin
                    ref_q      <= code_i;
                    have_ref_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/bemf_sense.sv
// Back-EMF rotor position sampler top level.
// Steers the comparator mux, synchronizes the comparator, decodes a sector
// code and filters it by repeat-until-agreement. Requests are taken only
// when no sequence is running.
module bemf_sense
    import bemf_pkg::*;
#(
    parameter int SETTLE      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       cmp_i,
    output logic [1:0] mux_pair_o,
    output logic       mux_pol_o,
    output logic [2:0] pos_o,
    output logic       pos_valid_o
);
    logic      cmp_s;
    logic      active;
    logic      start;
    logic      done;
    logic      again;
    pos_code_t code;
    pair_e     pair;

    assign start      = req_i && !active;
    assign mux_pair_o = pair;

    bemf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cmp_i),
        .q_o   (cmp_s)
    );

    bemf_tree #(.SETTLE(SETTLE)) u_tree (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .again_i  (again),
        .cmp_s_i  (cmp_s),
        .pair_o   (pair),
        .pol_o    (mux_pol_o),
        .active_o (active),
        .done_o   (done),
        .code_o   (code)
    );

    bemf_agree u_agree (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start),
        .done_i  (done),
        .code_i  (code),
        .again_o (again),
        .pos_o   (pos_o),
        .valid_o (pos_valid_o)
    );
endmodule

// File: rtl/bemf_sense_checker.sv
// Property checker for bemf_sense, attached by bind below.
// Watches only the top-level ports; a dwell counter measures mux hold time.
module bemf_sense_checker #(
    parameter int SETTLE = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mux_pair_o,
    input logic       mux_pol_o,
    input logic [2:0] pos_o,
    input logic       pos_valid_o
);
    localparam int DW = $clog2(SETTLE + 1) + 1;

    logic [2:0]    sel_q;
    logic [DW-1:0] dwell_q;

    // Count how long the current mux setting has been held (saturating)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= 3'b100;
            dwell_q <= DW'(SETTLE);
        end else begin
            sel_q <= {mux_pair_o, mux_pol_o};
            if (sel_q != {mux_pair_o, mux_pol_o}) dwell_q <= DW'(1);
            else if (dwell_q < DW'(SETTLE))       dwell_q <= dwell_q + 1'b1;
        end
    end

    assert_settle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q != {mux_pair_o, mux_pol_o}) |-> (dwell_q >= DW'(SETTLE)));

    assert_first_pair_pol_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_pair_o == 2'd1) |-> !mux_pol_o);

    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pos_valid_o |=> !pos_valid_o);

    assert_code_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pos_valid_o |-> (pos_o != 3'd0 && pos_o != 3'd7));

    assert_pos_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pos_valid_o |-> $stable(pos_o));

    // R3 and R4: codes 2 and 5 end on step two, the others on step three
    assert_final_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pos_valid_o |-> (mux_pair_o == ((pos_o == 3'd2 || pos_o == 3'd5) ? 2'd0 : 2'd2)));
endmodule

bind bemf_sense bemf_sense_checker #(.SETTLE(SETTLE)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .mux_pair_o  (mux_pair_o),
    .mux_pol_o   (mux_pol_o),
    .pos_o       (pos_o),
    .pos_valid_o (pos_valid_o)
);

// File: tb/bemf_sense_bench.sv
module bemf_sense_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_i = 1'b0;
    logic       cmp_i = 1'b0;
    logic [1:0] mux_pair_o;
    logic       mux_pol_o;
    logic [2:0] pos_o;
    logic       pos_valid_o;

    int errors = 0;
    int checks = 0;

    logic [2:0] ord [4];
    int         idx = -1;
    logic [1:0] last_pair = 2'd2;

    always #2.5 clk = ~clk;

    bemf_sense u_bemf_sense (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .cmp_i       (cmp_i),
        .mux_pair_o  (mux_pair_o),
        .mux_pol_o   (mux_pol_o),
        .pos_o       (pos_o),
        .pos_valid_o (pos_valid_o)
    );

    // vector: {m0, m1, m2, m3, expected code, measurements}; code 7 = all equal
    localparam logic [17:0] VEC [11] = '{
        {3'd5, 3'd5, 3'd0, 3'd0, 3'd5, 3'd2},
        {3'd1, 3'd1, 3'd0, 3'd0, 3'd1, 3'd2},
        {3'd6, 3'd6, 3'd0, 3'd0, 3'd6, 3'd2},
        {3'd2, 3'd2, 3'd0, 3'd0, 3'd2, 3'd2},
        {3'd3, 3'd3, 3'd0, 3'd0, 3'd3, 3'd2},
        {3'd4, 3'd4, 3'd0, 3'd0, 3'd4, 3'd2},
        {3'd7, 3'd7, 3'd0, 3'd0, 3'd6, 3'd2},
        {3'd3, 3'd4, 3'd4, 3'd0, 3'd4, 3'd3},
        {3'd1, 3'd2, 3'd1, 3'd1, 3'd1, 3'd4},
        {3'd2, 3'd5, 3'd2, 3'd2, 3'd2, 3'd4},
        {3'd5, 3'd6, 3'd6, 3'd0, 3'd6, 3'd3}
    };

    // Phase voltages {A, B, C} that produce each sector ordering
    function automatic logic [11:0] volts(input logic [2:0] c);
        case (c)
            3'd5:    return {4'd1, 4'd2, 4'd3};
            3'd1:    return {4'd3, 4'd1, 4'd2};
            3'd6:    return {4'd2, 4'd1, 4'd3};
            3'd2:    return {4'd3, 4'd2, 4'd1};
            3'd3:    return {4'd2, 4'd3, 4'd1};
            3'd4:    return {4'd1, 4'd3, 4'd2};
            default: return {4'd2, 4'd2, 4'd2};
        endcase
    endfunction

    function automatic int steps(input logic [2:0] c);
        return (c == 3'd5 || c == 3'd2) ? 2 : 3;
    endfunction

    // Comparator model following the R2 pair and polarity encoding
    function automatic logic model(input logic [1:0] pr, input logic pl, input logic [2:0] c);
        logic [11:0] v;
        logic [3:0]  va, vb, vc, vp, vn;
        v = volts(c);
        va = v[11:8]; vb = v[7:4]; vc = v[3:0];
        case (pr)
            2'd0:    begin vp = pl ? vb : va; vn = pl ? va : vb; end
            2'd1:    begin vp = pl ? vc : vb; vn = pl ? vb : vc; end
            default: begin vp = pl ? va : vc; vn = pl ? vc : va; end
        endcase
        return vp > vn;
    endfunction

    // Drive the comparator on falling edges; next measurement on a new pair-1 select
    initial begin
        forever begin
            @(negedge clk);
            if (mux_pair_o == 2'd1 && last_pair != 2'd1) idx++;
            last_pair = mux_pair_o;
            if (idx >= 0 && idx < 4) cmp_i = model(mux_pair_o, mux_pol_o, ord[idx]);
            else                     cmp_i = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Run one request; called on a falling edge
    task automatic run_case(input logic [11:0] ords, input logic [2:0] expc,
                            input int nm, input bit poke);
        int n = 0;
        int lat = 1;
        bit got = 0;
        string tag;
        for (int k = 0; k < 4; k++) ord[k] = ords[11-3*k -: 3];
        for (int k = 0; k < nm; k++) lat += 3 * steps(ord[k]);
        if (nm > 2)             tag = "R7";
        else if (ord[0] == 3'd7) tag = "R5";
        else if (expc == 3'd5 || expc == 3'd1 || expc == 3'd6) tag = "R3";
        else                     tag = "R4";
        idx = -1;
        req_i = 1'b1;
        while (!got && n < 600) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            req_i = poke && (n == 5);
            if (pos_valid_o) got = 1;
        end
        req_i = 1'b0;
        check(got, "R8 strobe seen", int'(got), 1);
        check(pos_o == expc, tag, int'(pos_o), int'(expc));
        check(n == lat, poke ? "R9 latency" : "R6 latency", n, lat);
        check(idx + 1 == nm, "R7 measurements", idx + 1, nm);
        @(negedge clk);
        check(!pos_valid_o, "R8 one-cycle strobe", int'(pos_valid_o), 0);
        check(pos_o == expc, "R8 code held", int'(pos_o), int'(expc));
        if (poke) begin
            bit extra = 0;
            logic [1:0] p0 = mux_pair_o;
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                if (pos_valid_o || mux_pair_o != p0) extra = 1;
            end
            check(!extra, "R9 no second sequence", int'(extra), 0);
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R6: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(pos_valid_o == 1'b0, "R1 valid in reset", int'(pos_valid_o), 0);
        check(pos_o == 3'd0, "R1 code in reset", int'(pos_o), 0);
        check(mux_pair_o == 2'd2 && !mux_pol_o, "R1 parked mux", int'({mux_pair_o, mux_pol_o}), 4);
        rst_n = 1'b1;
        begin
            bit seen = 0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (pos_valid_o || mux_pair_o != 2'd2) seen = 1;
            end
            check(!seen, "R1 idle without request", int'(seen), 0);
        end

        // Table of stimulus and expected results
        for (int v = 0; v < 11; v++) begin
            run_case(VEC[v][17:6], VEC[v][5:3], int'(VEC[v][2:0]), 1'b0);
            repeat (2) @(negedge clk);
        end

        // R2: mux schedule of a three-step measurement (code 1)
        ord[0] = 3'd1; ord[1] = 3'd1; ord[2] = 3'd0; ord[3] = 3'd0;
        idx = -1;
        req_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_i = 1'b0;
        check(mux_pair_o == 2'd1 && !mux_pol_o, "R2 step one B+ C-", int'({mux_pair_o, mux_pol_o}), 2);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(mux_pair_o == 2'd0 && mux_pol_o, "R2 step two B+ A-", int'({mux_pair_o, mux_pol_o}), 1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(mux_pair_o == 2'd2 && mux_pol_o, "R2 step three A+ C-", int'({mux_pair_o, mux_pol_o}), 5);
        begin
            int n = 0;
            while (!pos_valid_o && n < 100) begin
                @(negedge clk);
                n++;
            end
            check(pos_o == 3'd1, "R2 schedule result", int'(pos_o), 1);
        end
        repeat (2) @(negedge clk);

        // R9: second request during a running sequence
        run_case({3'd3, 3'd4, 3'd4, 3'd0}, 3'd4, 3, 1'b1);

        // R1: reset in the middle of a measurement
        ord[0] = 3'd3; ord[1] = 3'd3; ord[2] = 3'd0; ord[3] = 3'd0;
        idx = -1;
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(pos_o == 3'd0 && !pos_valid_o, "R1 mid-run reset outputs", int'(pos_o), 0);
        check(mux_pair_o == 2'd2 && !mux_pol_o, "R1 mid-run reset mux", int'({mux_pair_o, mux_pol_o}), 4);
        rst_n = 1'b1;
        @(negedge clk);
        run_case({3'd4, 3'd4, 3'd0, 3'd0}, 3'd4, 2, 1'b0);

        finish_run();
    end
endmodule